// File: doc/BRIEF.md
# Grouped-Priority Channel Allocator

This block hands out free channels from a pool of up to 32 to a requester, one channel per request. Each channel belongs to a priority class given by `(index mod 16) / 4`, and class 0 is the most preferred. Channels 0–3 and 16–19 therefore form the top class, 4–7 and 20–23 the next class, and so on. On each request the allocator grants the lowest-numbered free channel of the most preferred class that still has a free channel. If no channel is free, it reports a failure instead.

A requester raises `alloc_req` for one cycle. In the following cycle `gnt_valid` is high, together with either a channel index or `gnt_fail`. The granted channel is recorded in a busy bitmap, which is also visible on `busy_map`. When the requester is done, it returns the channel with `rel_valid` and `rel_idx`. If a release and a request fall in the same cycle, the release is applied first, so the freed channel is available to that same request.

Only classes up to `((NUM_CH-1) mod 16) / 4` are searched. With some channel counts this leaves part of the pool unreachable.

Top module: `challoc_top`

## Requirements
- R1: After reset, `busy_map` is all zeros and `gnt_valid`, `gnt_fail` and `gnt_idx` are zero.
- R2: Channel i has class (i mod 16)/4. A grant always comes from the lowest-numbered class that has a free reachable channel; for example, channel 16 is granted before channel 4, and channel 20 before channel 9.
- R3: Within a class, the free channel with the lowest index is granted.
- R4: `gnt_valid` is high in exactly the cycle after a cycle with `alloc_req` high, and low otherwise.
- R5: A granted channel has its `busy_map` bit set in the same cycle that the response appears, and one request sets at most one bit.
- R6: When no reachable channel is free, the response has `gnt_fail` = 1 and `gnt_idx` = 0, and `busy_map` is not changed.
- R7: A release with `rel_valid` = 1 clears bit `rel_idx` of `busy_map` in the next cycle, so that channel can be granted again.
- R8: When a release and a request occur in the same cycle, the release is applied first, and the released channel can be the one granted.
- R9: A release of a channel that is already free, or of an index ≥ `NUM_CH`, leaves `busy_map` and later grants unchanged.
- R10: Only classes 0 to ((NUM_CH-1) mod 16)/4 are searched. Channels in higher classes are never granted; with `NUM_CH` = 20, only channels 0–3 and 16–19 can be granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request one channel in this cycle |
| rel_valid | input | 1 | Return the channel given by `rel_idx` |
| rel_idx | input | IDX_W (5) | Index of the channel being returned |
| gnt_valid | output | 1 | A response to last cycle's request is present |
| gnt_fail | output | 1 | No channel was free for that request |
| gnt_idx | output | IDX_W (5) | Granted channel index (0 on failure) |
| busy_map | output | NUM_CH (32) | One bit per channel, set while the channel is held |

## Verification
The assertions assume that `rel_idx` matters only while `rel_valid` is high, and that each input is a known value in every cycle after reset. The release-clears property is checked only in cycles without a simultaneous request, because in those cycles the same channel may legally be granted again at once. The bench changes inputs only on the falling clock edge and returns each input to zero after a single cycle, so every request and release lasts exactly one cycle. A second instance with 20 channels covers the case where some classes are never searched.

// File: rtl/challoc_pkg.sv
package challoc_pkg;

    localparam int MAX_CH = 32;

    // Priority class of a channel: 0 is the most preferred.
    function automatic int cls_of(input int ch);
        return (ch % 16) / 4;
    endfunction

    // Highest class number that the search visits for a pool of n channels.
    function automatic int top_cls(input int n);
        return ((n - 1) % 16) / 4;
    endfunction

    // Bit set for every channel that the search can ever reach.
    function automatic logic [MAX_CH-1:0] reach_mask(input int n);
        logic [MAX_CH-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_CH; i++) begin
            if (i < n && cls_of(i) <= top_cls(n)) begin
                m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ch_release_dec.sv
module ch_release_dec #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5
) (
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [NUM_CH-1:0] mask_o
);

    // An index outside the pool matches no bit and is dropped.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            mask_o[i] = valid_i && (idx_i == IDX_W'(i));
        end
    end

endmodule

// File: rtl/ch_class_pick.sv
module ch_class_pick #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5,
    parameter int CLS    = 0
) (
    input  logic [NUM_CH-1:0] free_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);

    // Lowest free member of class CLS; a descending walk lets the last write win.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (challoc_pkg::cls_of(i) == CLS && free_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ch_class_arb.sv
module ch_class_arb #(
    parameter int NUM_CLS = 4,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_CLS-1:0]            hit_i,
    input  logic [NUM_CLS-1:0][IDX_W-1:0] idx_i,
    output logic                          found_o,
    output logic [IDX_W-1:0]              idx_o
);

    // Class 0 is the most preferred; a descending walk leaves the lowest class with a hit.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int c = NUM_CLS - 1; c >= 0; c--) begin
            if (hit_i[c]) begin
                found_o = 1'b1;
                idx_o   = idx_i[c];
            end
        end
    end

endmodule

// File: rtl/challoc_top.sv
module challoc_top #(
    parameter int NUM_CH = 32
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          alloc_req,
    input  logic                                          rel_valid,
    input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] rel_idx,
    output logic                                          gnt_valid,
    output logic                                          gnt_fail,
    output logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] gnt_idx,
    output logic [NUM_CH-1:0]                             busy_map
);

    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NUM_CLS = challoc_pkg::top_cls(NUM_CH) + 1;

    typedef struct packed {
        logic [NUM_CH-1:0] busy;
        logic              valid;
        logic              fail;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0]             rel_mask;
    logic [NUM_CH-1:0]             busy_rel;
    logic [NUM_CH-1:0]             free_vec;
    logic [NUM_CLS-1:0]            cls_hit;
    logic [NUM_CLS-1:0][IDX_W-1:0] cls_idx;
    logic                          pick_found;
    logic [IDX_W-1:0]              pick_idx;

    ch_release_dec #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_rel (
        .valid_i (rel_valid),
        .idx_i   (rel_idx),
        .mask_o  (rel_mask)
    );

    // The release takes effect before the search.
    assign busy_rel = st_q.busy & ~rel_mask;
    assign free_vec = ~busy_rel;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        ch_class_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .CLS(c)) u_pick (
            .free_i (free_vec),
            .hit_o  (cls_hit[c]),
            .idx_o  (cls_idx[c])
        );
    end

    ch_class_arb #(.NUM_CLS(NUM_CLS), .IDX_W(IDX_W)) u_arb (
        .hit_i   (cls_hit),
        .idx_i   (cls_idx),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.busy  = busy_rel;
        st_d.valid = alloc_req;
        st_d.fail  = 1'b0;
        st_d.idx   = '0;
        if (alloc_req) begin
            if (pick_found) begin
                st_d.busy[pick_idx] = 1'b1;
                st_d.idx            = pick_idx;
            end else begin
                st_d.fail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid = st_q.valid;
    assign gnt_fail  = st_q.fail;
    assign gnt_idx   = st_q.idx;
    assign busy_map  = st_q.busy;

endmodule

// File: rtl/challoc_chk.sv
module challoc_chk #(
    parameter int NUM_CH = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              rel_valid,
    input logic [IDX_W-1:0]  rel_idx,
    input logic              gnt_valid,
    input logic              gnt_fail,
    input logic [IDX_W-1:0]  gnt_idx,
    input logic [NUM_CH-1:0] busy_map
);

    localparam logic [31:0]       REACH   = challoc_pkg::reach_mask(NUM_CH);
    localparam logic [NUM_CH-1:0] REACH_N = REACH[NUM_CH-1:0];

    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |=> gnt_valid);                                           // R4
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req |=> !gnt_valid);                                         // R4
    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_fail) |-> busy_map[gnt_idx]);                    // R5
    AST_ONE_BIT_PER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(busy_map) <= $countones($past(busy_map)) + 1)); // R5
    AST_FAIL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_fail) |-> ((busy_map & REACH_N) == REACH_N));     // R6
    AST_FAIL_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && gnt_fail) |-> (gnt_idx == '0));                       // R6
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !alloc_req && (32'(rel_idx) < NUM_CH))
        |=> !busy_map[$past(rel_idx)]);                                     // R7
    AST_REACHABLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_map & ~REACH_N) == '0);                                       // R10

endmodule

bind challoc_top challoc_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (alloc_req),
    .rel_valid (rel_valid),
    .rel_idx   (rel_idx),
    .gnt_valid (gnt_valid),
    .gnt_fail  (gnt_fail),
    .gnt_idx   (gnt_idx),
    .busy_map  (busy_map)
);

// File: tb/tb_challoc_top.sv
`timescale 1ns/1ps
module tb_challoc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, rel = 1'b0;
    logic [4:0]  ridx = '0;
    logic        gv, gf;
    logic [4:0]  gi;
    logic [31:0] bm;

    logic        req20 = 1'b0, rel20 = 1'b0;
    logic [4:0]  ridx20 = '0;
    logic        gv20, gf20;
    logic [4:0]  gi20;
    logic [19:0] bm20;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    challoc_top #(.NUM_CH(32)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_req(req), .rel_valid(rel), .rel_idx(ridx),
        .gnt_valid(gv), .gnt_fail(gf), .gnt_idx(gi), .busy_map(bm)
    );

    challoc_top #(.NUM_CH(20)) dut20 (
        .clk(clk), .rst_n(rst_n), .alloc_req(req20), .rel_valid(rel20), .rel_idx(ridx20),
        .gnt_valid(gv20), .gnt_fail(gf20), .gnt_idx(gi20), .busy_map(bm20)
    );

    typedef struct packed {
        logic       req;
        logic       rel;
        logic [4:0] ridx;
        logic       efail;
        logic [4:0] eidx;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd0},   // R3 first of class 0
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd1},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd2},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd3},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd16},  // R2 16 ahead of 4
        '{1'b0, 1'b1, 5'd1,  1'b0, 5'd0},   // R7 release 1
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd1},   // R3 lowest again
        '{1'b1, 1'b1, 5'd2,  1'b0, 5'd2},   // R8 same-cycle release
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd17},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd18},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd19},
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd4},   // R2 next class
        '{1'b0, 1'b1, 5'd30, 1'b0, 5'd0},   // R9 release of free channel
        '{1'b1, 1'b0, 5'd0,  1'b0, 5'd5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge: drive for one cycle, return at the next falling edge.
    task automatic step(input logic r, input logic l, input logic [4:0] i);
        req = r; rel = l; ridx = i;
        @(negedge clk);
        req = 1'b0; rel = 1'b0; ridx = '0;
    endtask

    task automatic step20(input logic r);
        req20 = r;
        @(negedge clk);
        req20 = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_all;
        do_reset();
        chk("R1 busy after reset", bm, 32'h0);
        chk("R1 valid after reset", {31'h0, gv}, 32'h0);
        chk("R1 fail/idx after reset", {26'h0, gf, gi}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v].req, VEC[v].rel, VEC[v].ridx);
            if (VEC[v].req) begin
                chk("R4 valid", {31'h0, gv}, 32'h1);
                chk("R2/R3/R8 idx", {27'h0, gi}, {27'h0, VEC[v].eidx});
                chk("R6 fail flag", {31'h0, gf}, {31'h0, VEC[v].efail});
            end else begin
                chk("R4 no response", {31'h0, gv}, 32'h0);
            end
        end
        chk("R5/R9 busy after table", bm, 32'h000F_003F);

        do_reset();
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 32; i++) begin
                if (challoc_pkg::cls_of(i) == c) begin
                    step(1'b1, 1'b0, '0);
                    chk("R2 sweep idx", {27'h0, gi}, 32'(i));
                    chk("R5 bit set", {31'h0, bm[i]}, 32'h1);
                end
            end
        end
        step(1'b1, 1'b0, '0);
        chk("R6 fail when full", {30'h0, gv, gf}, 32'h3);
        chk("R6 fail idx zero", {27'h0, gi}, 32'h0);
        chk("R6 busy unchanged", bm, 32'hFFFF_FFFF);

        step(1'b0, 1'b1, 5'd9);
        chk("R7 release clears 9", bm, 32'hFFFF_FDFF);
        step(1'b0, 1'b1, 5'd20);
        step(1'b1, 1'b0, '0);
        chk("R2 class 1 (20) before class 2 (9)", {27'h0, gi}, 32'd20);
        step(1'b1, 1'b0, '0);
        chk("R7 released 9 granted again", {27'h0, gi}, 32'd9);
        step(1'b1, 1'b0, '0);
        chk("R6 fail after refill", {31'h0, gf}, 32'h1);

        for (int k = 0; k < 8; k++) begin
            step20(1'b1);
            chk("R10 reachable order", {27'h0, gi20}, (k < 4) ? 32'(k) : 32'(k + 12));
        end
        step20(1'b1);
        chk("R10 fail with unreachable free", {30'h0, gv20, gf20}, 32'h3);
        chk("R10 busy pattern", {12'h0, bm20}, 32'h000F_000F);

        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset busy", bm, 32'h0);
        chk("R1 mid-run reset valid", {31'h0, gv}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule